// File: doc/BRIEF.md
# Coprocessor System Control Register File

This block sits beside a processor core and services its coprocessor register transfers. Each request names a primary register number (CRn), a secondary number (CRm) and an opcode2 selector, and either writes a 32-bit word into the block or reads one back. The stored words control the data and instruction caches, the write buffer, eight protection regions and the two tightly-coupled memories (TCMs).

When a TCM control word is written, the block computes the matching memory window and holds it on dedicated outputs. The data TCM gets a base and a size. The instruction TCM gets a size only. Any one region is decoded through a combinational query port. Side effects leave the block as single-cycle pulses: an undefined-instruction pulse for a write to the read-only identity register, a bad-access pulse for selectors that are not defined, and a halt request for the wait-for-interrupt encoding. The opcode1 field plays no part in decoding and has no port.

Top module: `sysctl_regfile`

## Requirements
- R1: An accepted write with CRn=0 raises `undef_o` for exactly one cycle, in the cycle after acceptance. It changes no stored word and no derived output.
- R2: An accepted write with CRn=2 stores the data cache word when opcode2=0 and the instruction cache word when opcode2=1. The new value appears on `dcache_ctl_o` or `icache_ctl_o` in the cycle after acceptance.
- R3: An accepted write with CRn=3 and opcode2=0 stores the write-buffer word, which appears on `wbuf_ctl_o` in the next cycle.
- R4: The following accesses raise `bad_op_o` for one cycle and change nothing:
  - a CRn=2 write with opcode2 above 1;
  - a CRn=3 write with opcode2 other than 0;
  - a CRn=6 write with CRm of 8 or more;
  - a CRn=9 access, read or write, with opcode2 above 1.
- R5: An accepted write with CRn=6 and CRm below 8 stores protection region word CRm. The query port returns three values for the word selected by `region_idx_i`:
  - the word itself;
  - the base, which is word[31:12] placed at bit 12, with the low 12 bits zero;
  - the size, which is 2 shifted left by word[5:1], truncated to 32 bits. A cleared word therefore reports size 2.
- R6: An accepted write with CRn=7, CRm=0 and opcode2=4 raises `halt_req_o` for one cycle. Every other CRn=7 write has no visible effect.
- R7: An accepted write with CRn=9 and opcode2=0 stores the data TCM word. On the next cycle `dtcm_base_o` equals word[31:12] placed at bit 12, and `dtcm_size_o` equals 512 shifted left by word[5:1], truncated to 32 bits.
- R8: An accepted write with CRn=9 and opcode2=1 stores the instruction TCM word and sets `itcm_size_o` to 512 shifted left by word[5:1], truncated to 32 bits. `dtcm_base_o` stays unchanged.
- R9: An accepted read raises `rd_valid_o` in the next cycle. `rd_data_o` then carries:
  - the data TCM word for CRn=9, opcode2=0;
  - the instruction TCM word for CRn=9, opcode2=1;
  - zero for every other read.
- R10: Writes to CRn values with no function (1, 4, 5, 8, 10 to 15) complete without any pulse and without changing any output.
- R11: While `rst_ni` is low, every stored word, every derived base and size, every pulse and `req_ready_o` are zero. `req_ready_o` rises on the first clock edge after reset is released.
- R12: At most one of `undef_o`, `bad_op_o` and `halt_req_o` is high in any cycle. A request is accepted only in a cycle where `req_valid_i` and `req_ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block can accept a request |
| req_write_i | input | 1 | 1 = move to block, 0 = move from block |
| req_crn_i | input | 4 | Primary register number |
| req_crm_i | input | 4 | Secondary register number |
| req_op2_i | input | 3 | Opcode2 selector |
| req_wdata_i | input | 32 | Write value |
| rd_valid_o | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data_o | output | 32 | Read data |
| undef_o | output | 1 | Undefined-instruction pulse |
| bad_op_o | output | 1 | Bad-access pulse |
| halt_req_o | output | 1 | Halt request pulse |
| dcache_ctl_o | output | 32 | Data cache control word |
| icache_ctl_o | output | 32 | Instruction cache control word |
| wbuf_ctl_o | output | 32 | Write-buffer control word |
| dtcm_ctl_o | output | 32 | Data TCM control word |
| itcm_ctl_o | output | 32 | Instruction TCM control word |
| dtcm_base_o | output | 32 | Data TCM base |
| dtcm_size_o | output | 32 | Data TCM size in bytes |
| itcm_size_o | output | 32 | Instruction TCM size in bytes |
| region_idx_i | input | 3 | Protection region to query |
| region_ctl_o | output | 32 | Queried region word |
| region_base_o | output | 32 | Queried region base |
| region_size_o | output | 32 | Queried region size |

## Verification
The hardest cases to reach are the accesses that must leave no trace. A bad selector or an illegal write can only be told apart from a correct one by showing that no word moved. The stimulus therefore first loads every register with a distinct nonzero value. It then sends writes with bad opcode2 values, an out-of-range CRm, the read-only CRn, a CRn=7 write that is not the halt encoding, and unused CRn values, each carrying a different data word. After that it reads every control output and the region query port back. The size truncation at the top of the shift range is reached by writing size fields of 22 and 23.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int unsigned CRN_W = 4;
  localparam int unsigned CRM_W = 4;
  localparam int unsigned OP2_W = 3;

  localparam logic [CRN_W-1:0] CRN_IDENT   = 4'd0;
  localparam logic [CRN_W-1:0] CRN_CACHE   = 4'd2;
  localparam logic [CRN_W-1:0] CRN_WBUF    = 4'd3;
  localparam logic [CRN_W-1:0] CRN_REGION  = 4'd6;
  localparam logic [CRN_W-1:0] CRN_CACHEOP = 4'd7;
  localparam logic [CRN_W-1:0] CRN_TCM     = 4'd9;
  localparam logic [OP2_W-1:0] OP2_WFI     = 3'd4;

  typedef enum logic [1:0] {RD_ZERO, RD_DTCM, RD_ITCM} rd_sel_e;

  typedef struct packed {
    logic dcache;
    logic icache;
    logic wbuf;
    logic region;
    logic dtcm;
    logic itcm;
  } wr_en_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned N_REGION = 8
) (
  input  logic             acc_i,
  input  logic             wr_i,
  input  logic [CRN_W-1:0] crn_i,
  input  logic [CRM_W-1:0] crm_i,
  input  logic [OP2_W-1:0] op2_i,
  output wr_en_t           we_o,
  output logic             undef_o,
  output logic             bad_o,
  output logic             halt_o,
  output logic             rd_o,
  output rd_sel_e          rd_sel_o
);
  always_comb begin
    we_o     = '0;
    undef_o  = 1'b0;
    bad_o    = 1'b0;
    halt_o   = 1'b0;
    rd_o     = 1'b0;
    rd_sel_o = RD_ZERO;
    if (acc_i) begin
      if (wr_i) begin
        unique case (crn_i)
          CRN_IDENT: undef_o = 1'b1;
          CRN_CACHE: begin
            if (op2_i == 3'd0)      we_o.dcache = 1'b1;
            else if (op2_i == 3'd1) we_o.icache = 1'b1;
            else                    bad_o = 1'b1;
          end
          CRN_WBUF: begin
            if (op2_i == 3'd0) we_o.wbuf = 1'b1;
            else               bad_o = 1'b1;
          end
          CRN_REGION: begin
            if (32'(crm_i) < N_REGION) we_o.region = 1'b1;
            else                       bad_o = 1'b1;
          end
          CRN_CACHEOP: halt_o = (crm_i == '0) && (op2_i == OP2_WFI);
          CRN_TCM: begin
            if (op2_i == 3'd0)      we_o.dtcm = 1'b1;
            else if (op2_i == 3'd1) we_o.itcm = 1'b1;
            else                    bad_o = 1'b1;
          end
          default: ;
        endcase
      end else begin
        rd_o = 1'b1;
        if (crn_i == CRN_TCM) begin
          if (op2_i == 3'd0)      rd_sel_o = RD_DTCM;
          else if (op2_i == 3'd1) rd_sel_o = RD_ITCM;
          else                    bad_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sysctl_tcm.sv
module sysctl_tcm #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned UNIT   = 512,
  parameter int unsigned SZ_LSB = 1,
  parameter int unsigned SZ_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] word_o,
  output logic [DATA_W-1:0] size_o
);
  logic [DATA_W-1:0] word_q, size_q;

  // size held in its own register so reset reads zero, not UNIT
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      size_q <= '0;
    end else if (we_i) begin
      word_q <= wdata_i;
      size_q <= DATA_W'(UNIT) << wdata_i[SZ_LSB +: SZ_W];
    end
  end

  assign word_o = word_q;
  assign size_o = size_q;

  // R7
  tcm_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (word_o == $past(wdata_i)));
endmodule

// File: rtl/sysctl_regions.sv
module sysctl_regions #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_REGION = 8,
  parameter int unsigned UNIT     = 2,
  parameter int unsigned BASE_LSB = 12,
  parameter int unsigned SZ_LSB   = 1,
  parameter int unsigned SZ_W     = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [$clog2(N_REGION)-1:0] wr_idx_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [$clog2(N_REGION)-1:0] rd_idx_i,
  output logic [DATA_W-1:0]           ctl_o,
  output logic [DATA_W-1:0]           base_o,
  output logic [DATA_W-1:0]           size_o
);
  localparam int unsigned IDX_W = $clog2(N_REGION);

  logic [DATA_W-1:0] word_q [N_REGION];

  for (genvar g = 0; g < N_REGION; g++) begin : g_rgn
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 word_q[g] <= '0;
      else if (we_i && (wr_idx_i == IDX_W'(g)))    word_q[g] <= wdata_i;
    end
  end

  assign ctl_o  = word_q[rd_idx_i];
  assign base_o = {ctl_o[DATA_W-1:BASE_LSB], BASE_LSB'(0)};
  assign size_o = DATA_W'(UNIT) << ctl_o[SZ_LSB +: SZ_W];

  // R5
  rgn_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (wr_idx_i == rd_idx_i)) |=> ((ctl_o == $past(wdata_i)) || (rd_idx_i != $past(rd_idx_i))));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned N_REGION = 8,
  parameter int unsigned TCM_UNIT = 512,
  parameter int unsigned RGN_UNIT = 2,
  parameter int unsigned BASE_LSB = 12,
  parameter int unsigned SZ_LSB   = 1,
  parameter int unsigned SZ_W     = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic                        req_write_i,
  input  logic [3:0]                  req_crn_i,
  input  logic [3:0]                  req_crm_i,
  input  logic [2:0]                  req_op2_i,
  input  logic [DATA_W-1:0]           req_wdata_i,
  output logic                        rd_valid_o,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        undef_o,
  output logic                        bad_op_o,
  output logic                        halt_req_o,
  output logic [DATA_W-1:0]           dcache_ctl_o,
  output logic [DATA_W-1:0]           icache_ctl_o,
  output logic [DATA_W-1:0]           wbuf_ctl_o,
  output logic [DATA_W-1:0]           dtcm_ctl_o,
  output logic [DATA_W-1:0]           itcm_ctl_o,
  output logic [DATA_W-1:0]           dtcm_base_o,
  output logic [DATA_W-1:0]           dtcm_size_o,
  output logic [DATA_W-1:0]           itcm_size_o,
  input  logic [$clog2(N_REGION)-1:0] region_idx_i,
  output logic [DATA_W-1:0]           region_ctl_o,
  output logic [DATA_W-1:0]           region_base_o,
  output logic [DATA_W-1:0]           region_size_o
);
  localparam int unsigned IDX_W = $clog2(N_REGION);

  logic              ready_q, acc;
  wr_en_t            we;
  logic              dec_undef, dec_bad, dec_halt, dec_rd;
  rd_sel_e           rd_sel;
  logic              undef_q, bad_q, halt_q, rd_valid_q;
  logic [DATA_W-1:0] rd_data_q, dcache_q, icache_q, wbuf_q;
  logic [DATA_W-1:0] dtcm_word, itcm_word;

  assign acc = req_valid_i && ready_q;

  sysctl_decode #(.N_REGION(N_REGION)) u_decode (
    .acc_i   (acc),
    .wr_i    (req_write_i),
    .crn_i   (req_crn_i),
    .crm_i   (req_crm_i),
    .op2_i   (req_op2_i),
    .we_o    (we),
    .undef_o (dec_undef),
    .bad_o   (dec_bad),
    .halt_o  (dec_halt),
    .rd_o    (dec_rd),
    .rd_sel_o(rd_sel)
  );

  sysctl_tcm #(.DATA_W(DATA_W), .UNIT(TCM_UNIT), .SZ_LSB(SZ_LSB), .SZ_W(SZ_W)) u_dtcm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we.dtcm),
    .wdata_i(req_wdata_i),
    .word_o (dtcm_word),
    .size_o (dtcm_size_o)
  );

  sysctl_tcm #(.DATA_W(DATA_W), .UNIT(TCM_UNIT), .SZ_LSB(SZ_LSB), .SZ_W(SZ_W)) u_itcm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we.itcm),
    .wdata_i(req_wdata_i),
    .word_o (itcm_word),
    .size_o (itcm_size_o)
  );

  sysctl_regions #(
    .DATA_W(DATA_W), .N_REGION(N_REGION), .UNIT(RGN_UNIT),
    .BASE_LSB(BASE_LSB), .SZ_LSB(SZ_LSB), .SZ_W(SZ_W)
  ) u_regions (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we.region),
    .wr_idx_i(req_crm_i[IDX_W-1:0]),
    .wdata_i (req_wdata_i),
    .rd_idx_i(region_idx_i),
    .ctl_o   (region_ctl_o),
    .base_o  (region_base_o),
    .size_o  (region_size_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q    <= 1'b0;
      undef_q    <= 1'b0;
      bad_q      <= 1'b0;
      halt_q     <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      dcache_q   <= '0;
      icache_q   <= '0;
      wbuf_q     <= '0;
    end else begin
      ready_q    <= 1'b1;
      undef_q    <= dec_undef;
      bad_q      <= dec_bad;
      halt_q     <= dec_halt;
      rd_valid_q <= dec_rd;
      if (dec_rd) begin
        unique case (rd_sel)
          RD_DTCM: rd_data_q <= dtcm_word;
          RD_ITCM: rd_data_q <= itcm_word;
          default: rd_data_q <= '0;
        endcase
      end
      if (we.dcache) dcache_q <= req_wdata_i;
      if (we.icache) icache_q <= req_wdata_i;
      if (we.wbuf)   wbuf_q   <= req_wdata_i;
    end
  end

  assign req_ready_o  = ready_q;
  assign undef_o      = undef_q;
  assign bad_op_o     = bad_q;
  assign halt_req_o   = halt_q;
  assign rd_valid_o   = rd_valid_q;
  assign rd_data_o    = rd_data_q;
  assign dcache_ctl_o = dcache_q;
  assign icache_ctl_o = icache_q;
  assign wbuf_ctl_o   = wbuf_q;
  assign dtcm_ctl_o   = dtcm_word;
  assign itcm_ctl_o   = itcm_word;
  assign dtcm_base_o  = {dtcm_word[DATA_W-1:BASE_LSB], BASE_LSB'(0)};

  // R1
  undef_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> ($stable(dcache_ctl_o) && $stable(icache_ctl_o) && $stable(wbuf_ctl_o)
                 && $stable(dtcm_ctl_o) && $stable(itcm_ctl_o) && $stable(dtcm_size_o)
                 && $stable(itcm_size_o)));

  // R8
  itcm_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we.itcm |=> $stable(dtcm_base_o));

  // R9
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(req_valid_i && req_ready_o && !req_write_i));

  // R12
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({undef_o, bad_op_o, halt_req_o}));
endmodule

// File: tb/sysctl_regfile_tb.sv
`timescale 1ns/1ps
module sysctl_regfile_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [3:0]  req_crn_i = '0;
  logic [3:0]  req_crm_i = '0;
  logic [2:0]  req_op2_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [2:0]  region_idx_i = '0;
  logic        req_ready_o, rd_valid_o, undef_o, bad_op_o, halt_req_o;
  logic [31:0] rd_data_o, dcache_ctl_o, icache_ctl_o, wbuf_ctl_o, dtcm_ctl_o, itcm_ctl_o;
  logic [31:0] dtcm_base_o, dtcm_size_o, itcm_size_o, region_ctl_o, region_base_o, region_size_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  sysctl_regfile u_dut (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_crn_i, .req_crm_i,
    .req_op2_i, .req_wdata_i, .rd_valid_o, .rd_data_o, .undef_o, .bad_op_o, .halt_req_o,
    .dcache_ctl_o, .icache_ctl_o, .wbuf_ctl_o, .dtcm_ctl_o, .itcm_ctl_o, .dtcm_base_o,
    .dtcm_size_o, .itcm_size_o, .region_idx_i, .region_ctl_o, .region_base_o, .region_size_o
  );

  typedef struct packed {
    logic        wr;
    logic [3:0]  crn;
    logic [3:0]  crm;
    logic [2:0]  op2;
    logic [31:0] wd;
    logic        undef;
    logic        bad;
    logic        halt;
    logic [31:0] rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd0, 4'd0, 3'd0, 32'h0000_DEAD, 1'b1, 1'b0, 1'b0, 32'h0,          4'd1},  // R1
    '{1'b0, 4'd0, 4'd0, 3'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,          4'd9},  // R9
    '{1'b1, 4'd2, 4'd0, 3'd0, 32'h0000_0011, 1'b0, 1'b0, 1'b0, 32'h0,          4'd2},  // R2
    '{1'b1, 4'd2, 4'd0, 3'd1, 32'h0000_0022, 1'b0, 1'b0, 1'b0, 32'h0,          4'd2},  // R2
    '{1'b1, 4'd2, 4'd0, 3'd2, 32'h0000_0099, 1'b0, 1'b1, 1'b0, 32'h0,          4'd4},  // R4
    '{1'b1, 4'd3, 4'd0, 3'd0, 32'h0000_0033, 1'b0, 1'b0, 1'b0, 32'h0,          4'd3},  // R3
    '{1'b1, 4'd3, 4'd0, 3'd1, 32'h0000_0077, 1'b0, 1'b1, 1'b0, 32'h0,          4'd4},  // R4
    '{1'b1, 4'd9, 4'd0, 3'd0, 32'h0800_000A, 1'b0, 1'b0, 1'b0, 32'h0,          4'd7},  // R7
    '{1'b0, 4'd9, 4'd0, 3'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0800_000A,  4'd9},  // R9
    '{1'b1, 4'd9, 4'd0, 3'd1, 32'hFFFF_F010, 1'b0, 1'b0, 1'b0, 32'h0,          4'd8},  // R8
    '{1'b0, 4'd9, 4'd0, 3'd1, 32'h0,         1'b0, 1'b0, 1'b0, 32'hFFFF_F010,  4'd9},  // R9
    '{1'b0, 4'd9, 4'd0, 3'd2, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0,          4'd4},  // R4
    '{1'b1, 4'd9, 4'd0, 3'd5, 32'h0000_00FF, 1'b0, 1'b1, 1'b0, 32'h0,          4'd4},  // R4
    '{1'b1, 4'd7, 4'd0, 3'd4, 32'h0,         1'b0, 1'b0, 1'b1, 32'h0,          4'd6},  // R6
    '{1'b1, 4'd7, 4'd1, 3'd4, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,          4'd6},  // R6
    '{1'b1, 4'd6, 4'd3, 3'd0, 32'h1234_5016, 1'b0, 1'b0, 1'b0, 32'h0,          4'd5},  // R5
    '{1'b1, 4'd6, 4'd9, 3'd0, 32'hAAAA_AAAA, 1'b0, 1'b1, 1'b0, 32'h0,          4'd4},  // R4
    '{1'b1, 4'd1, 4'd0, 3'd0, 32'h5555_5555, 1'b0, 1'b0, 1'b0, 32'h0,          4'd10}, // R10
    '{1'b1, 4'd5, 4'd0, 3'd0, 32'h6666_6666, 1'b0, 1'b0, 1'b0, 32'h0,          4'd10}, // R10
    '{1'b0, 4'd2, 4'd0, 3'd0, 32'h0,         1'b0, 1'b0, 1'b0, 32'h0,          4'd9}   // R9
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge with results visible
  task automatic issue(input logic wr, input logic [3:0] crn, input logic [3:0] crm,
                       input logic [2:0] op2, input logic [31:0] wd);
    req_valid_i = 1'b1;
    req_write_i = wr;
    req_crn_i   = crn;
    req_crm_i   = crm;
    req_op2_i   = op2;
    req_wdata_i = wd;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic check_state(input string tag);
    chk({tag, " dcache"}, dcache_ctl_o, 32'h11);
    chk({tag, " icache"}, icache_ctl_o, 32'h22);
    chk({tag, " wbuf"},   wbuf_ctl_o,   32'h33);
    chk({tag, " dtcm"},   dtcm_ctl_o,   32'h0800_000A);
    chk({tag, " itcm"},   itcm_ctl_o,   32'hFFFF_F010);
    chk({tag, " dbase"},  dtcm_base_o,  32'h0800_0000);
    chk({tag, " dsize"},  dtcm_size_o,  32'h0000_4000);
    chk({tag, " isize"},  itcm_size_o,  32'h0002_0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 ready", {31'b0, req_ready_o}, 0);
    chk("R11 pulses", {29'b0, undef_o, bad_op_o, halt_req_o}, 0);
    chk("R11 dcache", dcache_ctl_o, 0);
    chk("R11 dsize", dtcm_size_o, 0);
    chk("R11 isize", itcm_size_o, 0);
    chk("R11 dbase", dtcm_base_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 ready after release", {31'b0, req_ready_o}, 1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      issue(VEC[i].wr, VEC[i].crn, VEC[i].crm, VEC[i].op2, VEC[i].wd);
      chk({tag, " undef"}, {31'b0, undef_o}, {31'b0, VEC[i].undef});
      chk({tag, " bad"},   {31'b0, bad_op_o}, {31'b0, VEC[i].bad});
      chk({tag, " halt"},  {31'b0, halt_req_o}, {31'b0, VEC[i].halt});
      chk({tag, " rdv"},   {31'b0, rd_valid_o}, {31'b0, !VEC[i].wr});
      if (!VEC[i].wr) chk({tag, " rdata"}, rd_data_o, VEC[i].rd);
    end

    // R12 pulses last one cycle
    @(negedge clk_i);
    chk("R12 idle pulses", {28'b0, undef_o, bad_op_o, halt_req_o, rd_valid_o}, 0);

    // R2 R3 R4 R7 R8 R10 stored state after good, bad and no-op writes
    check_state("R4");
    // R5 region query
    region_idx_i = 3'd3;
    #1;
    chk("R5 rgn ctl",  region_ctl_o,  32'h1234_5016);
    chk("R5 rgn base", region_base_o, 32'h1234_5000);
    chk("R5 rgn size", region_size_o, 32'h0000_1000);
    region_idx_i = 3'd1;
    #1;
    chk("R4 rgn1 untouched", region_ctl_o, 32'h0);
    chk("R5 rgn1 size", region_size_o, 32'h2);

    // R1 illegal write changes nothing
    issue(1'b1, 4'd0, 4'd0, 3'd0, 32'hFFFF_FFFF);
    chk("R1 undef", {31'b0, undef_o}, 1);
    check_state("R1");
    // R10 unused CRn 4
    issue(1'b1, 4'd4, 4'd0, 3'd0, 32'h1357_9BDF);
    chk("R10 no pulse", {29'b0, undef_o, bad_op_o, halt_req_o}, 0);
    check_state("R10");

    // R7 size truncation at top of shift range
    issue(1'b1, 4'd9, 4'd0, 3'd0, 32'h0000_002C);
    chk("R7 size 22", dtcm_size_o, 32'h8000_0000);
    chk("R7 base", dtcm_base_o, 32'h0);
    issue(1'b1, 4'd9, 4'd0, 3'd0, 32'h0000_002E);
    chk("R7 size 23", dtcm_size_o, 32'h0);
    // R8 itcm write leaves dtcm base
    issue(1'b1, 4'd9, 4'd0, 3'd0, 32'hABCD_E000);
    issue(1'b1, 4'd9, 4'd0, 3'd1, 32'h1111_1002);
    chk("R8 dbase kept", dtcm_base_o, 32'hABCD_E000);
    chk("R8 isize", itcm_size_o, 32'h0000_0400);

    // R11 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R11 rst dtcm", dtcm_ctl_o, 0);
    chk("R11 rst isize", itcm_size_o, 0);
    chk("R11 rst wbuf", wbuf_ctl_o, 0);
    chk("R11 rst ready", {31'b0, req_ready_o}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule